// File: doc/BRIEF.md
# I2C Controller Register and Interrupt Unit

This block is the host-facing register file of a master-only I2C controller. A simple host bus reads and writes 16-bit registers selected by a 4-bit index. The unit holds control, status, interrupt-enable, DMA configuration, byte count, own address and target address. It also raises one interrupt line and two DMA request lines, one for receive and one for transmit. A separate transfer engine reports events through single-cycle status-set pulses and hardware clear pulses. The unit passes control, byte count and target address back to that engine.

The parameter `NEW_REV` selects between two register behaviours. The newer revision has a six-bit enable register, and reading the vector register acknowledges the reported source. The older revision has a five-bit enable register, its vector reads do not acknowledge, and writing control with the enable bit clear returns every register to its reset value.

Top module: `i2c_reg_unit`

## Requirements
- R1: After a synchronous reset, every stored register reads 0, and `irq`, `drq_rx` and `drq_tx` are low.
- R2: A control write stores the written value ANDed with 0xCF87. The controller enable is bit 15. The stored value appears on `ctrl_o`.
- R3: A status write clears only the bits set in both the written value and 0x0027, which covers NACK (bit 1) and ARDY (bit 2). The receive-ready bit RRDY (bit 3) and the transmit-ready bit XRDY (bit 4) keep their value. `hw_clr[0]` clears RRDY and `hw_clr[1]` clears XRDY.
- R4: Each `evt_set` bit within 0x8C1E sets the matching status bit: 1, 2, 3, 4, 10, 11 or 15. Other `evt_set` bits are dropped. A set and a clear in the same cycle leave the bit set.
- R5: An enable write keeps the written value ANDed with 0x3F when `NEW_REV`=1, and ANDed with 0x1F when `NEW_REV`=0.
- R6: `irq` is high exactly when status AND enable is nonzero.
- R7: A DMA-configuration write keeps only bit 15 (receive DMA) and bit 7 (transmit DMA). Writing bit 15 as 1 clears enable bit 3. Writing bit 7 as 1 clears enable bit 4.
- R8: `drq_rx` equals RRDY while receive DMA is on, and is low otherwise. `drq_tx` equals XRDY while transmit DMA is on, and is low otherwise.
- R9: A vector read returns the index of the lowest set bit of status AND enable, or 0 when that value is zero. When `NEW_REV`=1 the read also clears the reported status bit. When `NEW_REV`=0 it clears nothing.
- R10: The own-address and target-address registers keep 10 bits (value AND 0x03FF). The byte count keeps all 16 bits. `tgt_addr_o` and `count_o` show the stored values.
- R11: A status read also returns `bus_busy` in bit 12, which is not stored. The system-status register returns the control enable bit in bit 0. The identity register returns `REV_ID`. Writes to identity, vector and system-status have no effect.
- R12: When `NEW_REV`=0, a control write with bit 15 clear resets all registers. When `NEW_REV`=1, such a write only stores control.
- R13: Register indices are: 0 identity, 1 control, 2 status, 3 enable, 4 vector, 5 system status, 6 DMA configuration, 7 byte count, 8 own address, 9 target address. Other indices read 0. Read data appears with `rd_valid` one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Register index |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 16 | Read data |
| evt_set | input | 16 | Status-set pulses from the transfer engine |
| hw_clr | input | 2 | Hardware clear of RRDY (bit 0) and XRDY (bit 1) |
| bus_busy | input | 1 | Bus-busy indication from the line monitor |
| irq | output | 1 | Interrupt request |
| drq_rx | output | 1 | Receive DMA request |
| drq_tx | output | 1 | Transmit DMA request |
| ctrl_o | output | 16 | Stored control value |
| count_o | output | 16 | Stored byte count |
| tgt_addr_o | output | 10 | Stored target address |

## Verification
The hardest case to reach is a status-set pulse and a host clear that hit the same status bit in the same cycle. The stimulus drives the event pulse and the status write on the same falling edge, then reads status back to confirm the bit survived. The acknowledge-on-read behaviour of the vector also needs care: the bench reads the vector three times in a row, which walks down the pending sources until the vector reads zero. A second instance built with the older revision confirms that its vector reads do not acknowledge, and that a control write with the enable bit clear wipes every register.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;
    localparam int DW   = 16;
    localparam int AW   = 4;
    localparam int IE_W = 6;
    localparam int ADDR_W = 10;

    typedef enum logic [AW-1:0] {
        RG_ID   = 4'd0,
        RG_CTRL = 4'd1,
        RG_STAT = 4'd2,
        RG_IEN  = 4'd3,
        RG_VEC  = 4'd4,
        RG_SYS  = 4'd5,
        RG_DMA  = 4'd6,
        RG_CNT  = 4'd7,
        RG_OWN  = 4'd8,
        RG_TGT  = 4'd9
    } reg_e;

    localparam logic [DW-1:0] CTRL_KEEP = 16'hCF87;
    localparam logic [DW-1:0] STAT_W1C  = 16'h0027;
    localparam logic [DW-1:0] STAT_HOLD = 16'h8C1E;
    localparam int SB_RRDY = 3;
    localparam int SB_XRDY = 4;
    localparam int SB_BUSY = 12;
    localparam int CB_EN   = 15;
    localparam int DB_RX   = 15;
    localparam int DB_TX   = 7;

    typedef struct packed {
        logic rx;
        logic tx;
    } dma_t;

    function automatic logic [3:0] low_index(input logic [IE_W-1:0] v);
        logic [3:0] r;
        r = '0;
        for (int i = IE_W - 1; i >= 0; i--) begin
            if (v[i]) r = 4'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/i2cr_status.sv
module i2cr_status
    import i2cr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          soft_rst,
    input  logic [DW-1:0] host_clr,
    input  logic [DW-1:0] vec_clr,
    input  logic [DW-1:0] evt_set,
    input  logic [1:0]    hw_clr,
    output logic [DW-1:0] stat_q
);
    logic [DW-1:0] nxt;

    always_comb begin
        nxt = stat_q & ~host_clr & ~vec_clr;
        if (hw_clr[0]) nxt[SB_RRDY] = 1'b0;
        if (hw_clr[1]) nxt[SB_XRDY] = 1'b0;
        nxt = nxt | (evt_set & STAT_HOLD);
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) stat_q <= '0;
        else                 stat_q <= nxt;
    end
endmodule

// File: rtl/i2cr_irq.sv
module i2cr_irq
    import i2cr_pkg::*;
(
    input  logic [DW-1:0]   stat,
    input  logic [IE_W-1:0] ien,
    input  dma_t            dma,
    output logic            irq,
    output logic            drq_rx,
    output logic            drq_tx,
    output logic            vec_hit,
    output logic [3:0]      vec_code
);
    logic [IE_W-1:0] pend;

    always_comb begin
        pend     = stat[IE_W-1:0] & ien;
        irq      = |pend;
        vec_hit  = |pend;
        vec_code = low_index(pend);
        drq_rx   = dma.rx & stat[SB_RRDY];
        drq_tx   = dma.tx & stat[SB_XRDY];
    end
endmodule

// File: rtl/i2c_reg_unit.sv
module i2c_reg_unit
    import i2cr_pkg::*;
#(
    parameter bit          NEW_REV = 1'b1,
    parameter logic [15:0] REV_ID  = 16'h0034
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [3:0]        req_addr,
    input  logic [15:0]       req_wdata,
    output logic              rd_valid,
    output logic [15:0]       rd_data,
    input  logic [15:0]       evt_set,
    input  logic [1:0]        hw_clr,
    input  logic              bus_busy,
    output logic              irq,
    output logic              drq_rx,
    output logic              drq_tx,
    output logic [15:0]       ctrl_o,
    output logic [15:0]       count_o,
    output logic [9:0]        tgt_addr_o
);
    localparam logic [IE_W-1:0] IEN_KEEP = NEW_REV ? 6'h3F : 6'h1F;

    reg_e              sel;
    logic              wr, rd, soft_rst;
    logic [DW-1:0]     ctrl_q, cnt_q, stat_q, host_clr, vec_clr;
    logic [IE_W-1:0]   ien_q;
    dma_t              dma_q;
    logic [ADDR_W-1:0] own_q, tgt_q;
    logic              vec_hit;
    logic [3:0]        vec_code;

    always_comb begin
        sel      = reg_e'(req_addr);
        wr       = req_valid &&  req_write;
        rd       = req_valid && !req_write;
        soft_rst = !NEW_REV && wr && sel == RG_CTRL && !req_wdata[CB_EN];
        host_clr = (wr && sel == RG_STAT) ? (req_wdata & STAT_W1C) : '0;
        vec_clr  = (NEW_REV && rd && sel == RG_VEC && vec_hit)
                   ? (DW'(1) << vec_code) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            ctrl_q <= '0;
            cnt_q  <= '0;
            ien_q  <= '0;
            dma_q  <= '0;
            own_q  <= '0;
            tgt_q  <= '0;
        end else if (wr) begin
            case (sel)
                RG_CTRL: ctrl_q <= req_wdata & CTRL_KEEP;
                RG_CNT:  cnt_q  <= req_wdata;
                RG_OWN:  own_q  <= req_wdata[ADDR_W-1:0];
                RG_TGT:  tgt_q  <= req_wdata[ADDR_W-1:0];
                RG_IEN:  ien_q  <= req_wdata[IE_W-1:0] & IEN_KEEP;
                RG_DMA: begin
                    dma_q.rx <= req_wdata[DB_RX];
                    dma_q.tx <= req_wdata[DB_TX];
                    if (req_wdata[DB_RX]) ien_q[SB_RRDY] <= 1'b0;
                    if (req_wdata[DB_TX]) ien_q[SB_XRDY] <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    i2cr_status u_stat (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .host_clr (host_clr),
        .vec_clr  (vec_clr),
        .evt_set  (evt_set),
        .hw_clr   (hw_clr),
        .stat_q   (stat_q)
    );

    i2cr_irq u_irq (
        .stat     (stat_q),
        .ien      (ien_q),
        .dma      (dma_q),
        .irq      (irq),
        .drq_rx   (drq_rx),
        .drq_tx   (drq_tx),
        .vec_hit  (vec_hit),
        .vec_code (vec_code)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd;
            if (rd) begin
                case (sel)
                    RG_ID:   rd_data <= REV_ID;
                    RG_CTRL: rd_data <= ctrl_q;
                    RG_STAT: rd_data <= stat_q | (DW'(bus_busy) << SB_BUSY);
                    RG_IEN:  rd_data <= DW'(ien_q);
                    RG_VEC:  rd_data <= DW'(vec_code);
                    RG_SYS:  rd_data <= DW'(ctrl_q[CB_EN]);
                    RG_DMA:  rd_data <= (DW'(dma_q.rx) << DB_RX) | (DW'(dma_q.tx) << DB_TX);
                    RG_CNT:  rd_data <= cnt_q;
                    RG_OWN:  rd_data <= DW'(own_q);
                    RG_TGT:  rd_data <= DW'(tgt_q);
                    default: rd_data <= '0;
                endcase
            end
        end
    end

    assign ctrl_o     = ctrl_q;
    assign count_o    = cnt_q;
    assign tgt_addr_o = tgt_q;
endmodule

// File: rtl/i2cr_chk.sv
module i2cr_chk
    import i2cr_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_write,
    input logic [3:0]    req_addr,
    input logic          wdata_rx,
    input logic          evt_nack,
    input logic          evt_rrdy,
    input logic          hwclr_rrdy,
    input logic          rd_valid,
    input logic          drq_rx,
    input logic [15:0]   ctrl_o,
    input logic          stat_nack,
    input logic          stat_rrdy,
    input logic          ien_rrdy,
    input logic          dma_rx
);
    logic wr_any;
    assign wr_any = req_valid && req_write;

    AST_CTRL_MASK: assert property (@(posedge clk) disable iff (rst)
        (wr_any && req_addr == RG_CTRL) |=> ((ctrl_o & ~CTRL_KEEP) == 16'h0)); // R2

    AST_RRDY_NOT_HOST_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (wr_any && req_addr == RG_STAT && stat_rrdy && !hwclr_rrdy) |=> stat_rrdy); // R3

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (evt_nack && !(wr_any && req_addr == RG_CTRL)) |=> stat_nack); // R4

    AST_DMA_DROPS_IEN: assert property (@(posedge clk) disable iff (rst)
        (wr_any && req_addr == RG_DMA && wdata_rx) |=> !ien_rrdy); // R7

    AST_DRQ_RX_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (evt_rrdy && dma_rx && !wr_any) |=> drq_rx); // R8

    AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rd_valid); // R13
endmodule

bind i2c_reg_unit i2cr_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .wdata_rx   (req_wdata[15]),
    .evt_nack   (evt_set[1]),
    .evt_rrdy   (evt_set[3]),
    .hwclr_rrdy (hw_clr[0]),
    .rd_valid   (rd_valid),
    .drq_rx     (drq_rx),
    .ctrl_o     (ctrl_o),
    .stat_nack  (stat_q[1]),
    .stat_rrdy  (stat_q[3]),
    .ien_rrdy   (ien_q[3]),
    .dma_rx     (dma_q.rx)
);

// File: tb/sim_i2c_reg_unit.sv
`timescale 1ns/1ps
module sim_i2c_reg_unit;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst = 1'b1;
    logic        rv0 = 1'b0, rv1 = 1'b0, req_write = 1'b0;
    logic [3:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [15:0] evt0 = '0, evt1 = '0;
    logic [1:0]  hw0 = '0, hw1 = '0;
    logic        busy = 1'b0;

    logic        vld0, vld1, irq0, irq1, drx0, drx1, dtx0, dtx1;
    logic [15:0] rdd0, rdd1, ctrl0, ctrl1, cnt0, cnt1;
    logic [9:0]  tgt0, tgt1;

    i2c_reg_unit #(.NEW_REV(1'b1)) u0 (
        .clk(clk), .rst(rst), .req_valid(rv0), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(vld0), .rd_data(rdd0),
        .evt_set(evt0), .hw_clr(hw0), .bus_busy(busy), .irq(irq0),
        .drq_rx(drx0), .drq_tx(dtx0), .ctrl_o(ctrl0), .count_o(cnt0), .tgt_addr_o(tgt0));

    i2c_reg_unit #(.NEW_REV(1'b0)) u1 (
        .clk(clk), .rst(rst), .req_valid(rv1), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(vld1), .rd_data(rdd1),
        .evt_set(evt1), .hw_clr(hw1), .bus_busy(1'b0), .irq(irq1),
        .drq_rx(drx1), .drq_tx(dtx1), .ctrl_o(ctrl1), .count_o(cnt1), .tgt_addr_o(tgt1));

    int checks = 0, failures = 0;
    bit done = 1'b0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int s, input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        req_addr = a; req_wdata = d; req_write = 1'b1;
        if (s == 0) rv0 = 1'b1; else rv1 = 1'b1;
        @(negedge clk);
        rv0 = 1'b0; rv1 = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input int s, input logic [3:0] a, input logic [15:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        req_addr = a; req_write = 1'b0;
        if (s == 0) rv0 = 1'b1; else rv1 = 1'b1;
        @(negedge clk);
        rv0 = 1'b0; rv1 = 1'b0;
    endtask

    task automatic pulse(input int s, input logic [15:0] e, input logic [1:0] h);
        @(negedge clk);
        if (s == 0) begin evt0 = e; hw0 = h; end else begin evt1 = e; hw1 = h; end
        @(negedge clk);
        evt0 = '0; hw0 = '0; evt1 = '0; hw1 = '0;
    endtask

    // monitor: pop expected read data as responses appear
    always @(negedge clk) begin
        if (!rst && (vld0 || vld1)) begin
            if (exp_q.size() == 0) begin
                chk("R13 unexpected read response", vld0 ? rdd0 : rdd1, 16'hxxxx);
            end else begin
                automatic logic [15:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(t, vld0 ? rdd0 : rdd1, e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(0, 4'd1, 16'h0000, "R1 ctrl after reset");
        rd(0, 4'd2, 16'h0000, "R1 status after reset");
        rd(0, 4'd3, 16'h0000, "R1 enable after reset");
        rd(0, 4'd6, 16'h0000, "R1 dma after reset");
        chk("R1 irq after reset", 16'(irq0), 16'h0);
        chk("R1 drq after reset", 16'({drx0, dtx0}), 16'h0);

        // R2 control mask
        wr(0, 4'd1, 16'hFFFF);
        rd(0, 4'd1, 16'hCF87, "R2 ctrl masked");
        chk("R2 ctrl_o", ctrl0, 16'hCF87);

        // R11 read-only registers and sys status
        wr(0, 4'd5, 16'h1234);
        rd(0, 4'd5, 16'h0001, "R11 sys status shows enable");
        wr(0, 4'd0, 16'h0000);
        rd(0, 4'd0, 16'h0034, "R11 identity");
        wr(0, 4'd4, 16'hFFFF);
        rd(0, 4'd4, 16'h0000, "R11 vector write ignored");
        busy = 1'b1;
        rd(0, 4'd2, 16'h1000, "R11 busy bit 12");
        busy = 1'b0;
        rd(0, 4'd12, 16'h0000, "R13 unused index");

        // R4 event pulses
        pulse(0, 16'hFFFF, 2'b00);
        rd(0, 4'd2, 16'h8C1E, "R4 events set storable bits");

        // R3 write-one-to-clear subset
        wr(0, 4'd2, 16'hFFFF);
        rd(0, 4'd2, 16'h8C18, "R3 only nack/ardy cleared");
        chk("R6 irq low with zero enable", 16'(irq0), 16'h0);

        // R5 enable mask, R6 irq
        wr(0, 4'd3, 16'hFFFF);
        rd(0, 4'd3, 16'h003F, "R5 enable mask new");
        chk("R6 irq high", 16'(irq0), 16'h1);

        // R9 vector with acknowledge
        rd(0, 4'd4, 16'h0003, "R9 vector lowest rrdy");
        rd(0, 4'd4, 16'h0004, "R9 vector next xrdy");
        rd(0, 4'd4, 16'h0000, "R9 vector empty");
        rd(0, 4'd2, 16'h8C00, "R9 vector acknowledged bits");
        chk("R6 irq low after ack", 16'(irq0), 16'h0);

        // R7 DMA config
        wr(0, 4'd6, 16'hFFFF);
        rd(0, 4'd6, 16'h8080, "R7 dma kept bits");
        rd(0, 4'd3, 16'h0027, "R7 enable bits 3 and 4 cleared");

        // R8 DMA requests
        pulse(0, 16'h0008, 2'b00);
        chk("R8 drq_rx follows rrdy", 16'(drx0), 16'h1);
        chk("R8 drq_tx idle", 16'(dtx0), 16'h0);
        chk("R6 irq low rrdy not enabled", 16'(irq0), 16'h0);
        pulse(0, 16'h0000, 2'b01);
        chk("R8 drq_rx after hw clear", 16'(drx0), 16'h0);
        pulse(0, 16'h0010, 2'b00);
        chk("R8 drq_tx follows xrdy", 16'(dtx0), 16'h1);
        pulse(0, 16'h0000, 2'b10);
        chk("R8 drq_tx after hw clear", 16'(dtx0), 16'h0);

        // R4 set wins over host clear in the same cycle
        pulse(0, 16'h0010, 2'b00);
        @(negedge clk);
        evt0 = 16'h0002; req_addr = 4'd2; req_wdata = 16'h0002; req_write = 1'b1; rv0 = 1'b1;
        @(negedge clk);
        evt0 = '0; rv0 = 1'b0; req_write = 1'b0;
        rd(0, 4'd2, 16'h8C12, "R4 set beats clear");
        chk("R6 irq nack enabled", 16'(irq0), 16'h1);

        // R10 address and count
        wr(0, 4'd8, 16'hFFFF);
        rd(0, 4'd8, 16'h03FF, "R10 own address 10 bits");
        wr(0, 4'd9, 16'h7ABC);
        rd(0, 4'd9, 16'h02BC, "R10 target address 10 bits");
        chk("R10 tgt_addr_o", 16'(tgt0), 16'h02BC);
        wr(0, 4'd7, 16'hABCD);
        rd(0, 4'd7, 16'hABCD, "R10 count");
        chk("R10 count_o", cnt0, 16'hABCD);

        // R12 new revision: disabling does not reset
        wr(0, 4'd1, 16'h0000);
        rd(0, 4'd8, 16'h03FF, "R12 new rev keeps own address");

        // older revision instance
        wr(1, 4'd3, 16'hFFFF);
        rd(1, 4'd3, 16'h001F, "R5 enable mask old");
        wr(1, 4'd8, 16'h0155);
        wr(1, 4'd1, 16'h8000);
        rd(1, 4'd8, 16'h0155, "R12 old rev enabled keeps");
        pulse(1, 16'h0002, 2'b00);
        rd(1, 4'd4, 16'h0001, "R9 old vector");
        rd(1, 4'd4, 16'h0001, "R9 old vector no ack");
        chk("R6 old irq", 16'(irq1), 16'h1);
        wr(1, 4'd1, 16'h0004);
        rd(1, 4'd8, 16'h0000, "R12 old rev own address reset");
        rd(1, 4'd3, 16'h0000, "R12 old rev enable reset");
        rd(1, 4'd2, 16'h0000, "R12 old rev status reset");
        rd(1, 4'd1, 16'h0000, "R12 old rev ctrl reset");
        chk("R12 old irq low", 16'(irq1), 16'h0);

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) chk("R13 missing read responses", 16'(exp_q.size()), 16'h0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule